// File: doc/BRIEF.md
# Backplane Bus Glue Controller

This block sits between a CPU board with an asynchronous, strobe-based 16-bit bus and an expansion backplane. It produces a qualified address strobe that is active only for ordinary memory cycles. Cycles whose function code marks processor-internal space are excluded. It also raises an off-board select whenever a qualified cycle is not claimed by any on-board decoder, and external buffer logic can use that select.

The block also steers the direction of the backplane address, data and control buffers. It follows the bus request, grant and grant-acknowledge lines, so an external master that has taken the bus can reach peripherals on the CPU board. The direction register only updates between cycles, so the buffers never turn around while a strobe is active.

A reset sequencer drives the open-drain reset and halt lines through output enables. It runs at power-on and on a synchronous request. Both enables are held for at least 1 ms, with the hold computed from the clock-frequency parameter, and both are released on the same clock edge.

Top module: `bkpl_glue`

## Requirements
- R1: `qas_no` is low exactly when `as_ni` is low and `fc_i` differs from 3'b111; it follows its inputs combinationally.
- R2: `offboard_o` is high exactly when `qas_no` is low and `onboard_hit_i` is low.
- R3: External ownership is `bgack_ni` low, or `br_ni` and `bg_ni` both low. On a rising edge where `qas_no` is high, `buf_dir_o` takes the ownership value: 1 means the buffers drive from backplane to board, and 0 means board to backplane.
- R4: On a rising edge where `qas_no` is low, `buf_dir_o` keeps its value.
- R5: While `rst_ni` is low, `reset_oe_o` and `halt_oe_o` are high. They stay high until the HOLD_CYC-th rising edge after `rst_ni` rises, where HOLD_CYC = ceil(CLK_HZ * HOLD_US / 1e6). With the defaults this gives at least 1 ms.
- R6: When `rst_req_i` is sampled high on a rising edge, both enables are high after that edge and stay high for exactly HOLD_CYC cycles.
- R7: A request sampled while a sequence is running restarts the count, so the enables stay high for HOLD_CYC cycles after the latest request.
- R8: `reset_oe_o` and `halt_oe_o` are always equal and are released on the same edge.
- R9: While `rst_ni` is low, `buf_dir_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also acts as power-on |
| as_ni | input | 1 | CPU address strobe, active low |
| fc_i | input | 3 | Function code of the current cycle |
| onboard_hit_i | input | 1 | An on-board decoder claims the current address |
| br_ni | input | 1 | Bus request from backplane, active low |
| bg_ni | input | 1 | Bus grant, active low |
| bgack_ni | input | 1 | Bus grant acknowledge, active low |
| rst_req_i | input | 1 | Synchronous request to start a reset sequence |
| qas_no | output | 1 | Qualified address strobe, active low |
| buf_dir_o | output | 1 | Buffer direction: 1 backplane to board, 0 board to backplane |
| offboard_o | output | 1 | Valid address not claimed on board |
| reset_oe_o | output | 1 | Pull the open-drain reset line low |
| halt_oe_o | output | 1 | Pull the open-drain halt line low |

## Verification
The strobe and select logic is driven with random strobe, function-code and hit values. A directed case pairs an active strobe with function code 111 against one with 110, which separates the CPU-space exclusion from plain strobe gating. Random handshake combinations test each of the three ways a master can own the bus. A held strobe with ownership toggling underneath shows whether the direction is frozen mid-cycle or follows the handshake at once. Reset sequences are timed from power-on, from a lone request and from a second request halfway through, which separates a restarting counter from one that ignores or accumulates requests.

// File: rtl/bkpl_glue_pkg.sv
package bkpl_glue_pkg;
  localparam int unsigned FC_W = 3;
  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;

  // ceil(hz * us / 1e6), at least 1
  function automatic int unsigned hold_cycles(int unsigned hz, int unsigned us);
    longint unsigned p;
    p = (longint'(hz) * longint'(us) + 64'd999_999) / 64'd1_000_000;
    if (p == 0) p = 1;
    return int'(p);
  endfunction
endpackage

// File: rtl/bkpl_strb_qual.sv
module bkpl_strb_qual
  import bkpl_glue_pkg::*;
(
  input  logic            as_ni,
  input  logic [FC_W-1:0] fc_i,
  input  logic            hit_i,
  output logic            qas_no,
  output logic            offboard_o
);
  logic qas;

  always_comb begin
    qas        = !as_ni && (fc_i != FC_CPU_SPACE);
    qas_no     = !qas;
    offboard_o = qas && !hit_i;
  end
endmodule

// File: rtl/bkpl_buf_dir.sv
module bkpl_buf_dir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qas_ni,
  input  logic br_ni,
  input  logic bg_ni,
  input  logic bgack_ni,
  output logic dir_o
);
  logic ext_own;
  logic dir_q;

  always_comb ext_own = !bgack_ni || (!br_ni && !bg_ni);

  // turn around only between cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= 1'b0;
    else if (qas_ni) dir_q <= ext_own;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/bkpl_rst_seq.sv
module bkpl_rst_seq #(
  parameter int unsigned HOLD_CYC = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic reset_oe_o,
  output logic halt_oe_o
);
  localparam int unsigned CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (req_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // one flag drives both so release is simultaneous
  assign reset_oe_o = active_q;
  assign halt_oe_o  = active_q;
endmodule

// File: rtl/bkpl_glue.sv
module bkpl_glue
  import bkpl_glue_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 8_000_000,
  parameter int unsigned HOLD_US = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            as_ni,
  input  logic [FC_W-1:0] fc_i,
  input  logic            onboard_hit_i,
  input  logic            br_ni,
  input  logic            bg_ni,
  input  logic            bgack_ni,
  input  logic            rst_req_i,
  output logic            qas_no,
  output logic            buf_dir_o,
  output logic            offboard_o,
  output logic            reset_oe_o,
  output logic            halt_oe_o
);
  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_US);

  logic qas_n;

  bkpl_strb_qual u_strb (
    .as_ni      (as_ni),
    .fc_i       (fc_i),
    .hit_i      (onboard_hit_i),
    .qas_no     (qas_n),
    .offboard_o (offboard_o)
  );

  bkpl_buf_dir u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qas_ni   (qas_n),
    .br_ni    (br_ni),
    .bg_ni    (bg_ni),
    .bgack_ni (bgack_ni),
    .dir_o    (buf_dir_o)
  );

  bkpl_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (rst_req_i),
    .reset_oe_o (reset_oe_o),
    .halt_oe_o  (halt_oe_o)
  );

  assign qas_no = qas_n;
endmodule

// File: rtl/bkpl_glue_chk.sv
module bkpl_glue_chk
  import bkpl_glue_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 8_000_000,
  parameter int unsigned HOLD_US = 1000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            as_ni,
  input logic [FC_W-1:0] fc_i,
  input logic            onboard_hit_i,
  input logic            br_ni,
  input logic            bg_ni,
  input logic            bgack_ni,
  input logic            rst_req_i,
  input logic            qas_no,
  input logic            buf_dir_o,
  input logic            offboard_o,
  input logic            reset_oe_o
);
  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_US);

  logic [31:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= '0;
    else if (rst_req_i)  hi_cnt <= '0;
    else if (reset_oe_o) hi_cnt <= hi_cnt + 1;
  end

  // R1
  qas_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qas_no == (as_ni || fc_i == 3'b111));

  // R2
  offboard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offboard_o |-> (!qas_no && !onboard_hit_i));

  // R3
  dir_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qas_no && (!bgack_ni || (!br_ni && !bg_ni))) |=> buf_dir_o);

  // R4
  dir_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qas_no |=> $stable(buf_dir_o));

  // R6
  req_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> reset_oe_o);

  // R5
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_oe_o) |-> (hi_cnt >= HOLD_CYC));
endmodule

bind bkpl_glue bkpl_glue_chk #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .as_ni         (as_ni),
  .fc_i          (fc_i),
  .onboard_hit_i (onboard_hit_i),
  .br_ni         (br_ni),
  .bg_ni         (bg_ni),
  .bgack_ni      (bgack_ni),
  .rst_req_i     (rst_req_i),
  .qas_no        (qas_no),
  .buf_dir_o     (buf_dir_o),
  .offboard_o    (offboard_o),
  .reset_oe_o    (reset_oe_o)
);

// File: tb/bkpl_glue_tb.sv
module bkpl_glue_tb;
  import bkpl_glue_pkg::*;

  localparam int unsigned HZ   = 100_000;
  localparam int unsigned US   = 1000;
  localparam int unsigned HOLD = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_n = 1'b1;
  logic [2:0] fc = 3'd0;
  logic       hit = 1'b0;
  logic       br_n = 1'b1, bg_n = 1'b1, bgack_n = 1'b1;
  logic       req = 1'b0;
  logic       qas_n, dir, offb, roe, hoe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_dir;

  always #5 clk = ~clk;

  bkpl_glue #(.CLK_HZ(HZ), .HOLD_US(US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .fc_i(fc),
    .onboard_hit_i(hit), .br_ni(br_n), .bg_ni(bg_n), .bgack_ni(bgack_n),
    .rst_req_i(req), .qas_no(qas_n), .buf_dir_o(dir), .offboard_o(offb),
    .reset_oe_o(roe), .halt_oe_o(hoe)
  );

  function automatic logic f_qas_n(logic a, logic [2:0] f);
    return !(!a && f != 3'b111);
  endfunction

  function automatic logic f_own(logic br, logic bg, logic bk);
    return !bk || (!br && !bg);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_dir <= 1'b0;
    else if (f_qas_n(as_n, fc)) exp_dir <= f_own(br_n, bg_n, bgack_n);
  end

  task automatic chk(input bit ok, input string req_s, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
    end
  endtask

  // R8 on every cycle out of reset
  always @(negedge clk) if (rst_n && !done) chk(roe == hoe, "R8", int'(hoe), int'(roe));

  task automatic step(input logic a, input logic [2:0] f, input logic h,
                      input logic br, input logic bg, input logic bk);
    @(negedge clk);
    chk(dir == exp_dir, "R3/R4 dir", int'(dir), int'(exp_dir));
    as_n = a; fc = f; hit = h; br_n = br; bg_n = bg; bgack_n = bk;
    #1;
    chk(qas_n == f_qas_n(a, f), "R1", int'(qas_n), int'(f_qas_n(a, f)));
    chk(offb == (!f_qas_n(a, f) && !h), "R2", int'(offb), int'(!f_qas_n(a, f) && !h));
  endtask

  task automatic measure(output int n);
    n = roe ? 1 : 0;
    while (roe && n < 10 * HOLD) begin
      @(negedge clk);
      if (roe) n++;
    end
  endtask

  task automatic pulse_req;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(roe == 1'b1, "R5 reset oe", int'(roe), 1);
    chk(hoe == 1'b1, "R5 reset halt", int'(hoe), 1);
    chk(dir == 1'b0, "R9 reset dir", int'(dir), 0);

    // R5 power-on hold
    rst_n = 1'b1;
    measure(n);
    chk(n == HOLD, "R5 power-on length", n, HOLD);

    // R6 single request
    pulse_req();
    chk(roe == 1'b1, "R6 start", int'(roe), 1);
    measure(n);
    chk(n == HOLD, "R6 length", n, HOLD);

    // R7 restart mid-sequence
    pulse_req();
    repeat (40) @(negedge clk);
    pulse_req();
    measure(n);
    chk(n == HOLD, "R7 restart length", n, HOLD);

    // R1 CPU-space corner
    step(1'b0, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(qas_n == 1'b1 && offb == 1'b0, "R1 fc=111 excluded", int'(qas_n), 1);
    step(1'b0, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(qas_n == 1'b0 && offb == 1'b1, "R1 fc=110 passes", int'(qas_n), 0);
    step(1'b0, 3'b110, 1'b1, 1'b1, 1'b1, 1'b1);
    chk(offb == 1'b0, "R2 onboard hit", int'(offb), 0);

    // R4 freeze while strobe held, ownership flips underneath
    step(1'b1, 3'b001, 1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b1, 3'b001, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(dir == 1'b0, "R3 idle board drives", int'(dir), 0);
    step(1'b0, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(dir == 1'b0, "R4 frozen mid-cycle", int'(dir), 0);
    step(1'b1, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(dir == 1'b1, "R3 takes ownership", int'(dir), 1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(dir == 1'b1, "R3 request+grant", int'(dir), 1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(dir == 1'b0, "R3 request only", int'(dir), 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) != 0, 3'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule